// File: doc/BRIEF.md
# ISA I/O Slave Front End

This block sits between a 16-bit ISA-style I/O bus and a small internal register file. It compares the upper address bits against a configurable window base and detects the falling edges of the active-low read and write strobes. Each strobe edge inside the window performs exactly one register access. It drives the open-drain 16-bit chip-select and channel-ready lines as output enables, where an enable of 1 means "pull low".

The interface comes out of reset in byte mode. It moves to word transfers only after the active-low byte-high enable has been seen low and then high. While the refresh input is low, both strobes are ignored. A queue of 16-bit event words backs the interrupt request, and the request drops only when a popping read of that queue returns zero. The single interrupt request and the single DMA request are each steered onto one line of a bank. The other lines of each bank are left undriven.

The window spans 16 bytes, which is 8 word slots. Slot 0 is the control register and slots 1 to 3 are general registers. Slot 4 is the event queue. Slots 5 to 7 read as zero. Control bits: bit 0 disables read stalls, bits 2:1 pick the interrupt line, bits 4:3 pick the DMA line, and bit 7 is a self-clearing soft reset that always reads 0.

Top module: `isa_io_slave`

## Requirements
- R1: After reset the following hold: the interface is in byte mode; all registers read 0; interrupt line 0 and DMA line 0 are selected; the interrupt request is low; the event queue is empty; channel-ready is not pulled.
- R2: `cs16_oe` is 1 exactly when `addr[9:4]` equals `cfg_base[9:4]`, whatever the strobes.
- R3: A falling edge of `iow_n` inside the window writes the addressed register. A write whose address is outside the window changes no register.
- R4: While `refresh_n` is low, strobe edges cause no write, no queue pop and no read stall.
- R5: In byte mode, an even address accesses bits 7:0 and an odd address accesses bits 15:8. Write data is taken from `data_in[7:0]`, and read data is returned on `dout[7:0]` with `dout[15:8]` = 0.
- R6: Word mode is entered only after `sbhe_n` has gone low and then high. In word mode, an even address with `sbhe_n` low transfers all 16 bits; any other access is a byte access as in R5.
- R7: A read edge inside the window pulls `rdy_oe` for exactly STALL cycles (default 3) when control bit 0 is 0. It never pulls `rdy_oe` when that bit is 1.
- R8: The event queue takes nonzero `evt_word` values in FIFO order. Zero words are dropped, and words that arrive while the queue is full (depth 4) are dropped. A word read or odd-byte read of slot 4 pops one entry. An even-byte read returns the low byte without popping. An empty queue reads 0.
- R9: Each accepted event sets the interrupt request. The request clears only on a popping read of slot 4 while the queue is empty.
- R10: `irq_oe` is one-hot on the line chosen by control bits 2:1. Only that line carries the interrupt request.
- R11: `drq_oe` enables the line chosen by control bits 4:3 (value 3 selects none). The request on that line is `dma_need` gated by the same-index `dack_n`. Acknowledges on other lines have no effect.
- R12: Writing 1 to control bit 7 does three things: it returns the interface to byte mode, empties the queue and clears the interrupt request. The other control bits written in the same access are stored as 0 where bit 7 sits, and the general registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 10 | Window base address; bits 3:0 ignored |
| addr | input | 10 | Bus I/O address |
| data_in | input | 16 | Bus write data |
| iow_n | input | 1 | Write strobe, active low |
| ior_n | input | 1 | Read strobe, active low |
| refresh_n | input | 1 | Refresh indicator, active low |
| sbhe_n | input | 1 | Byte-high enable, active low |
| dout | output | 16 | Read data captured at the read edge |
| dout_oe | output | 1 | Read data drive enable |
| cs16_oe | output | 1 | Pull-low enable of the 16-bit chip select |
| rdy_oe | output | 1 | Pull-low enable of channel ready |
| evt_valid | input | 1 | Event word push strobe |
| evt_word | input | 16 | Event word |
| irq_o | output | 4 | Interrupt request lines |
| irq_oe | output | 4 | Interrupt line drive enables |
| dma_need | input | 1 | Internal DMA request |
| dack_n | input | 3 | DMA acknowledges, active low |
| drq_o | output | 3 | DMA request lines |
| drq_oe | output | 3 | DMA line drive enables |

## Verification
The bench first works through byte-lane writes whose upper data bits carry junk. A design that ignored the lane rules would store those bits. It then checks that an even-byte read of the queue does not pop, since a design that popped there would lose the high byte of every event. The entry into word mode is tested on both sides of the `sbhe_n` pulse. This exposes a design that treats a single low level as enough, and also one that stays in word mode after a soft reset. The remaining tests cover an overfilled queue, reads of an empty queue, refresh-masked strobes, and an acknowledge arriving on a line other than the selected one. These catch, in turn, a queue that overwrites entries, an interrupt that clears on any read, and a DMA request withdrawn by the wrong acknowledge.

// File: rtl/isa_slv_pkg.sv
package isa_slv_pkg;
  // control register field positions (slot 0)
  localparam int CTL_STALL_OFF = 0;
  localparam int CTL_IRQ_LSB   = 1;
  localparam int CTL_DMA_LSB   = 3;
  localparam int CTL_SRST      = 7;

  typedef enum logic [1:0] {
    LANE_LO   = 2'd0,
    LANE_HI   = 2'd1,
    LANE_WORD = 2'd2
  } lane_e;
endpackage

// File: rtl/isa_slv_decode.sv
module isa_slv_decode
  import isa_slv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              mode16,
  input  logic              sbhe_n,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output lane_e             lane
);
  localparam int TOP_LSB = IDX_W + 1;

  always_comb begin
    hit = (addr[ADDR_W-1:TOP_LSB] == base[ADDR_W-1:TOP_LSB]);
    idx = addr[IDX_W:1];
    if (mode16 && !sbhe_n && !addr[0]) lane = LANE_WORD;
    else if (addr[0])                  lane = LANE_HI;
    else                               lane = LANE_LO;
  end
endmodule

// File: rtl/isa_slv_isq.sv
module isa_slv_isq #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        push,
  input  logic [15:0] push_word,
  input  logic        pop,
  output logic [15:0] head,
  output logic        empty,
  output logic        full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [15:0]   mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? 16'h0000 : mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= push_word;
  end
endmodule

// File: rtl/isa_slv_route.sv
module isa_slv_route #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             req,
  output logic [N-1:0]     line_o,
  output logic [N-1:0]     line_oe
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign line_oe[g] = (sel == SEL_W'(g));
    assign line_o[g]  = line_oe[g] & req;
  end
endmodule

// File: rtl/isa_slv_stall.sv
module isa_slv_stall #(
  parameter int STALL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(STALL + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start && !busy) cnt_d = CW'(STALL);
    else if (busy)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/isa_io_slave.sv
module isa_io_slave
  import isa_slv_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int IDX_W     = 3,
  parameter int NREGS     = 4,
  parameter int ISQ_DEPTH = 4,
  parameter int STALL     = 3,
  parameter int N_IRQ     = 4,
  parameter int N_DMA     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       data_in,
  input  logic              iow_n,
  input  logic              ior_n,
  input  logic              refresh_n,
  input  logic              sbhe_n,
  output logic [15:0]       dout,
  output logic              dout_oe,
  output logic              cs16_oe,
  output logic              rdy_oe,
  input  logic              evt_valid,
  input  logic [15:0]       evt_word,
  output logic [N_IRQ-1:0]  irq_o,
  output logic [N_IRQ-1:0]  irq_oe,
  input  logic              dma_need,
  input  logic [N_DMA-1:0]  dack_n,
  output logic [N_DMA-1:0]  drq_o,
  output logic [N_DMA-1:0]  drq_oe
);
  localparam int ISQ_IDX = NREGS;
  localparam int IRQ_SW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int DMA_SW  = $clog2(N_DMA + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic             iow_q, ior_q;
  logic             seen_lo_q, seen_lo_d, mode16_q, mode16_d;
  logic             irq_pend_q, irq_pend_d;
  logic [15:0]      regs_q [NREGS];
  logic [15:0]      regs_d [NREGS];
  logic [15:0]      dout_q, dout_d, rsel;
  logic             hit, wr_ev, rd_ev, soft_rst;
  logic [IDX_W-1:0] idx;
  lane_e            lane;
  logic             isq_pop, isq_push, isq_empty, isq_full;
  logic [15:0]      isq_head;
  logic             stall_off, ack_low, drq_req;
  logic [DMA_SW-1:0] dma_sel;

  isa_slv_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .base(cfg_base), .mode16(mode16_q), .sbhe_n(sbhe_n),
    .hit(hit), .idx(idx), .lane(lane)
  );

  assign cs16_oe   = hit;
  assign dout_oe   = hit && !ior_n && refresh_n;
  assign wr_ev     = iow_q && !iow_n && refresh_n && hit;
  assign rd_ev     = ior_q && !ior_n && refresh_n && hit;
  assign stall_off = regs_q[0][CTL_STALL_OFF];
  assign soft_rst  = wr_ev && (idx == '0) && (lane != LANE_HI) && data_in[CTL_SRST];
  assign isq_pop   = rd_ev && (idx == IDX_W'(ISQ_IDX)) && (lane != LANE_LO);
  assign isq_push  = evt_valid && (evt_word != 16'h0000) && !isq_full;
  assign dma_sel   = regs_q[0][CTL_DMA_LSB +: DMA_SW];

  isa_slv_isq #(.DEPTH(ISQ_DEPTH)) u_isq (
    .clk(clk), .rst_n(rst_s), .flush(soft_rst), .push(isq_push),
    .push_word(evt_word), .pop(isq_pop), .head(isq_head),
    .empty(isq_empty), .full(isq_full)
  );

  isa_slv_stall #(.STALL(STALL)) u_stall (
    .clk(clk), .rst_n(rst_s), .start(rd_ev && !stall_off), .busy(rdy_oe)
  );

  // register file next state
  always_comb begin
    for (int i = 0; i < NREGS; i++) regs_d[i] = regs_q[i];
    if (wr_ev && (idx < IDX_W'(NREGS))) begin
      for (int i = 0; i < NREGS; i++) begin
        if (idx == IDX_W'(i)) begin
          case (lane)
            LANE_WORD: regs_d[i]       = data_in;
            LANE_HI:   regs_d[i][15:8] = data_in[7:0];
            default:   regs_d[i][7:0]  = data_in[7:0];
          endcase
        end
      end
    end
    regs_d[0][CTL_SRST] = 1'b0;
  end

  // read data path
  always_comb begin
    rsel = 16'h0000;
    for (int i = 0; i < NREGS; i++) begin
      if (idx == IDX_W'(i)) rsel = regs_q[i];
    end
    if (idx == IDX_W'(ISQ_IDX)) rsel = isq_head;
    case (lane)
      LANE_WORD: dout_d = rsel;
      LANE_HI:   dout_d = {8'h00, rsel[15:8]};
      default:   dout_d = {8'h00, rsel[7:0]};
    endcase
  end

  // mode and interrupt next state
  always_comb begin
    seen_lo_d  = seen_lo_q | ~sbhe_n;
    mode16_d   = mode16_q | (seen_lo_q & sbhe_n);
    irq_pend_d = irq_pend_q;
    if (isq_pop && isq_empty) irq_pend_d = 1'b0;
    if (isq_push)             irq_pend_d = 1'b1;
    if (soft_rst) begin
      seen_lo_d  = 1'b0;
      mode16_d   = 1'b0;
      irq_pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      iow_q      <= 1'b1;
      ior_q      <= 1'b1;
      seen_lo_q  <= 1'b0;
      mode16_q   <= 1'b0;
      irq_pend_q <= 1'b0;
      dout_q     <= '0;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else begin
      iow_q      <= iow_n;
      ior_q      <= ior_n;
      seen_lo_q  <= seen_lo_d;
      mode16_q   <= mode16_d;
      irq_pend_q <= irq_pend_d;
      if (rd_ev) dout_q <= dout_d;
      if (wr_ev) begin
        for (int i = 0; i < NREGS; i++) regs_q[i] <= regs_d[i];
      end
    end
  end

  assign dout = dout_q;

  // DMA acknowledge of the selected index only
  always_comb begin
    ack_low = 1'b0;
    for (int i = 0; i < N_DMA; i++) begin
      if (dma_sel == DMA_SW'(i)) ack_low = ~dack_n[i];
    end
  end
  assign drq_req = dma_need & ~ack_low;

  isa_slv_route #(.N(N_IRQ), .SEL_W(IRQ_SW)) u_irq_rt (
    .sel(regs_q[0][CTL_IRQ_LSB +: IRQ_SW]), .req(irq_pend_q),
    .line_o(irq_o), .line_oe(irq_oe)
  );

  isa_slv_route #(.N(N_DMA), .SEL_W(DMA_SW)) u_dma_rt (
    .sel(dma_sel), .req(drq_req), .line_o(drq_o), .line_oe(drq_oe)
  );
endmodule

// File: rtl/isa_io_slave_chk.sv
module isa_io_slave_chk #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int STALL  = 3,
  parameter int N_IRQ  = 4,
  parameter int N_DMA  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cfg_base,
  input logic              refresh_n,
  input logic              sbhe_n,
  input logic              cs16_oe,
  input logic              rdy_oe,
  input logic              stall_off,
  input logic              mode16,
  input logic              irq_pend,
  input logic              isq_pop,
  input logic              isq_empty,
  input logic              soft_rst,
  input logic [N_IRQ-1:0]  irq_o,
  input logic [N_IRQ-1:0]  irq_oe,
  input logic [N_DMA-1:0]  drq_o,
  input logic [N_DMA-1:0]  drq_oe
);
  localparam int RW = $clog2(STALL + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (rdy_oe) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_cs16_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs16_oe == (addr[ADDR_W-1:IDX_W+1] == cfg_base[ADDR_W-1:IDX_W+1]));

  p_refresh_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_oe) |-> $past(refresh_n));

  p_mode_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode16) |-> $past(sbhe_n));

  p_stall_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe |-> (run_q < RW'(STALL)));

  p_stall_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_oe) |-> $past(!stall_off));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pend) |-> $past(soft_rst || (isq_pop && isq_empty)));

  p_irq_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_oe) == 1);

  p_irq_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~irq_oe) == '0);

  p_drq_hiz_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((drq_o & ~drq_oe) == '0) && $onehot0(drq_oe));
endmodule

bind isa_io_slave isa_io_slave_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STALL(STALL), .N_IRQ(N_IRQ), .N_DMA(N_DMA)
) u_chk (
  .clk(clk), .rst_n(rst_s), .addr(addr), .cfg_base(cfg_base),
  .refresh_n(refresh_n), .sbhe_n(sbhe_n), .cs16_oe(cs16_oe), .rdy_oe(rdy_oe),
  .stall_off(stall_off), .mode16(mode16_q), .irq_pend(irq_pend_q),
  .isq_pop(isq_pop), .isq_empty(isq_empty), .soft_rst(soft_rst),
  .irq_o(irq_o), .irq_oe(irq_oe), .drq_o(drq_o), .drq_oe(drq_oe)
);

// File: tb/sim_isa_io_slave.sv
module sim_isa_io_slave;
  localparam int STALL = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  cfg_base, addr;
  logic [15:0] data_in, evt_word;
  logic        iow_n, ior_n, refresh_n, sbhe_n, evt_valid, dma_need;
  logic [2:0]  dack_n;
  logic [15:0] dout;
  logic        dout_oe, cs16_oe, rdy_oe;
  logic [3:0]  irq_o, irq_oe;
  logic [2:0]  drq_o, drq_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  isa_io_slave #(.STALL(STALL)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .addr(addr),
    .data_in(data_in), .iow_n(iow_n), .ior_n(ior_n), .refresh_n(refresh_n),
    .sbhe_n(sbhe_n), .dout(dout), .dout_oe(dout_oe), .cs16_oe(cs16_oe),
    .rdy_oe(rdy_oe), .evt_valid(evt_valid), .evt_word(evt_word),
    .irq_o(irq_o), .irq_oe(irq_oe), .dma_need(dma_need), .dack_n(dack_n),
    .drq_o(drq_o), .drq_oe(drq_oe)
  );

  typedef struct packed {
    logic        rd;
    logic [9:0]  a;
    logic [15:0] d;
  } vec_t;

  // byte mode vectors: writes carry junk in the upper data bits
  localparam vec_t VEC [10] = '{
    '{1'b0, 10'h302, 16'hEE5A},
    '{1'b0, 10'h303, 16'h99A5},
    '{1'b0, 10'h306, 16'h4411},
    '{1'b0, 10'h307, 16'h0022},
    '{1'b0, 10'h2F4, 16'h0077},
    '{1'b1, 10'h302, 16'h005A},
    '{1'b1, 10'h303, 16'h00A5},
    '{1'b1, 10'h306, 16'h0011},
    '{1'b1, 10'h307, 16'h0022},
    '{1'b1, 10'h304, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [15:0] d, input logic sb);
    @(negedge clk);
    addr = a; data_in = d; sbhe_n = sb; iow_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    iow_n = 1'b1; sbhe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [9:0] a, input logic sb,
                        output logic [15:0] v, output int st);
    st = 0;
    @(negedge clk);
    addr = a; sbhe_n = sb; ior_n = 1'b0;
    for (int k = 0; k < STALL + 2; k++) begin
      @(negedge clk);
      if (rdy_oe) st++;
    end
    v = dout;
    ior_n = 1'b1; sbhe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_evt(input logic [15:0] w);
    @(negedge clk);
    evt_valid = 1'b1; evt_word = w;
    @(negedge clk);
    evt_valid = 1'b0; evt_word = 16'h0000;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int st;
    rst_n = 1'b0; cfg_base = 10'h300; addr = 10'h000; data_in = '0;
    iow_n = 1'b1; ior_n = 1'b1; refresh_n = 1'b1; sbhe_n = 1'b1;
    evt_valid = 1'b0; evt_word = '0; dma_need = 1'b0; dack_n = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rdy_oe", rdy_oe, 0);
    chk("R1 irq_oe", irq_oe, 4'b0001);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 drq_oe", drq_oe, 3'b001);
    bus_rd(10'h300, 1'b1, v, st);
    chk("R1 ctrl reads 0", v, 0);
    bus_rd(10'h309, 1'b1, v, st);
    chk("R1 queue empty", v, 0);

    // R3 R5 vector walk, byte mode
    foreach (VEC[i]) begin
      if (VEC[i].rd) begin
        bus_rd(VEC[i].a, 1'b1, v, st);
        chk("R5 byte read", v, VEC[i].d);
        if (i == 5) chk("R7 stall length", st, STALL);
      end else begin
        bus_wr(VEC[i].a, VEC[i].d, 1'b1);
      end
    end

    // R2 window decode
    @(negedge clk); addr = 10'h30F;
    @(negedge clk); chk("R2 inside", cs16_oe, 1);
    addr = 10'h310;
    @(negedge clk); chk("R2 above", cs16_oe, 0);
    addr = 10'h2FF;
    @(negedge clk); chk("R2 below", cs16_oe, 0);

    // R4 refresh masks strobes
    refresh_n = 1'b0;
    bus_wr(10'h302, 16'h00FF, 1'b1);
    push_evt(16'h0BAD);
    bus_rd(10'h309, 1'b1, v, st);
    chk("R4 no stall in refresh", st, 0);
    refresh_n = 1'b1;
    bus_rd(10'h302, 1'b1, v, st);
    chk("R4 write ignored", v, 16'h005A);
    bus_rd(10'h308, 1'b1, v, st);
    chk("R4 no pop lo", v, 16'h00AD);
    bus_rd(10'h309, 1'b1, v, st);
    chk("R4 no pop hi", v, 16'h000B);

    // R7 stall disabled
    bus_wr(10'h300, 16'h0001, 1'b1);
    bus_rd(10'h302, 1'b1, v, st);
    chk("R7 stall off", st, 0);

    // R8 R9 queue in byte mode (queue is now empty, irq still pending)
    chk("R9 pending kept", irq_o, 4'b0001);
    push_evt(16'h1234);
    push_evt(16'h0000);
    push_evt(16'hBEEF);
    bus_rd(10'h308, 1'b1, v, st); chk("R8 lo no pop", v, 16'h0034);
    bus_rd(10'h308, 1'b1, v, st); chk("R8 lo again", v, 16'h0034);
    bus_rd(10'h309, 1'b1, v, st); chk("R8 hi pop", v, 16'h0012);
    bus_rd(10'h308, 1'b1, v, st); chk("R8 second lo", v, 16'h00EF);
    bus_rd(10'h309, 1'b1, v, st); chk("R8 second hi", v, 16'h00BE);
    chk("R9 irq after nonzero", irq_o, 4'b0001);
    bus_rd(10'h309, 1'b1, v, st); chk("R8 zero word dropped", v, 16'h0000);
    chk("R9 irq cleared", irq_o, 4'b0000);

    // R6 word mode entry
    bus_rd(10'h302, 1'b0, v, st);
    chk("R6 first access is byte", v, 16'h005A);
    @(negedge clk); sbhe_n = 1'b0;
    @(negedge clk); sbhe_n = 1'b1;
    @(negedge clk);
    bus_wr(10'h304, 16'hCAFE, 1'b0);
    bus_rd(10'h304, 1'b0, v, st);
    chk("R6 word access", v, 16'hCAFE);
    bus_wr(10'h305, 16'h1177, 1'b1);
    bus_rd(10'h304, 1'b0, v, st);
    chk("R6 byte in word mode", v, 16'h77FE);

    // R8 overflow, word reads
    for (int k = 1; k <= 5; k++) push_evt(16'(k));
    for (int k = 1; k <= 4; k++) begin
      bus_rd(10'h308, 1'b0, v, st);
      chk("R8 fifo order", v, 16'(k));
    end
    chk("R9 irq held", irq_o, 4'b0001);
    bus_rd(10'h308, 1'b0, v, st);
    chk("R8 full drop", v, 0);
    chk("R9 irq cleared word", irq_o, 0);

    // R10 R11 routing
    bus_wr(10'h300, 16'h000D, 1'b0);
    push_evt(16'h00A0);
    chk("R10 irq_oe", irq_oe, 4'b0100);
    chk("R10 irq_o", irq_o, 4'b0100);
    @(negedge clk); dma_need = 1'b1;
    @(negedge clk);
    chk("R11 drq_oe", drq_oe, 3'b010);
    chk("R11 drq_o", drq_o, 3'b010);
    dack_n = 3'b110;
    @(negedge clk); chk("R11 other ack", drq_o, 3'b010);
    dack_n = 3'b101;
    @(negedge clk); chk("R11 own ack", drq_o, 3'b000);
    chk("R11 oe kept", drq_oe, 3'b010);
    dack_n = 3'b111; dma_need = 1'b0;

    // R12 soft reset via low byte write with sbhe high
    bus_wr(10'h300, 16'h0080, 1'b1);
    chk("R12 irq cleared", irq_o, 0);
    chk("R12 ctrl cleared", irq_oe, 4'b0001);
    bus_wr(10'h302, 16'h3344, 1'b0);
    bus_rd(10'h302, 1'b0, v, st);
    chk("R12 byte mode after soft reset", v, 16'hA544);
    bus_rd(10'h308, 1'b0, v, st);
    chk("R12 queue flushed", v, 0);
    bus_rd(10'h300, 1'b0, v, st);
    chk("R12 srst bit reads 0", v, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule